// File: doc/BRIEF.md
# Scheduler Dispatch Stall and Issue Controller

This block sits between an instruction dispatch stage and the execution pipes of an out-of-order core. For the instruction offered on the dispatch port it returns a stall code every cycle. The code is built from scheduler buffer occupancy, a dispatch-group reservation flag and the fullness of the load and store queues. When the code says the instruction may proceed and the dispatch stage asserts valid, the block takes the instruction. It then issues the instruction on a bypass port in the same cycle, places it in the ready list, or places it in the wait list.

Operand readiness and memory-ordering clearance come from outside, as per-tag vectors. Each cycle the block first promotes waiting entries whose conditions now hold. It then grants the oldest eligible entry to the issue port. Load/store entries notify the load/store unit when they complete, and completion reports arrive on an execution-done port.

Top module: `sched_dispatch_ctrl`

## Requirements
- R1: `status_o` encodes 0 = go, 1 = load queue full, 2 = store queue full, 3 = scheduler buffers full, 4 = group stall. It reads 0 when no condition below blocks the offered instruction.
- R2: When all DEPTH slots are occupied, `status_o` is 3 regardless of every other input. Otherwise, when `grp_busy_i` is high, it is 4 regardless of the queue-full inputs.
- R3: Below those conditions, a load with `lq_full_i` gives 1 even if it is also a store with `sq_full_i`. A store with `sq_full_i` gives 2. An instruction that is neither load nor store ignores both queue-full inputs.
- R4: An instruction is taken only in a cycle with `disp_valid_i` high and `status_o` equal to 0. An offer under any other code changes no slot and issues nothing.
- R5: A taken instruction that is ready at dispatch and flagged zero-latency or in-order-only appears on `imm_valid_o`/`imm_tag_o` in that same cycle. It occupies no slot.
- R6: A taken instruction is held in the wait list when its operand bit is low, or when it is a memory operation whose ordering bit is low. It becomes eligible for issue in the same cycle in which both conditions first hold.
- R7: A taken instruction that is ready but not bypassed enters the ready list. The issue port grants at most one entry per cycle, always the oldest eligible one by dispatch order.
- R8: A slot is freed at the clock edge that ends its issue cycle, so the code reflects the lower occupancy in the following cycle.
- R9: A zero-latency memory operation raises its `lsu_done_o` bit in its issue cycle. Any other memory operation raises it in the cycle in which `exec_done_valid_i` reports its tag, once only. A non-memory instruction never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch offer valid |
| disp_tag_i | input | TAG_W | Tag of offered instruction |
| disp_load_i | input | 1 | Offered instruction reads memory |
| disp_store_i | input | 1 | Offered instruction writes memory |
| disp_zero_lat_i | input | 1 | Offered instruction has zero latency |
| disp_inorder_i | input | 1 | Uses only in-order resources, one unbuffered |
| grp_busy_i | input | 1 | Dispatch-group resource reserved |
| lq_full_i | input | 1 | Load queue full |
| sq_full_i | input | 1 | Store queue full |
| status_o | output | 3 | Stall code |
| opnd_rdy_i | input | 2**TAG_W | Operand readiness per tag |
| mem_ok_i | input | 2**TAG_W | Memory-ordering clearance per tag |
| imm_valid_o | output | 1 | Bypass issue this cycle |
| imm_tag_o | output | TAG_W | Bypass issue tag |
| iss_valid_o | output | 1 | List issue this cycle |
| iss_tag_o | output | TAG_W | List issue tag |
| exec_done_valid_i | input | 1 | Execution completion report |
| exec_done_tag_i | input | TAG_W | Completed tag |
| lsu_done_o | output | 2**TAG_W | Load/store unit completion notice per tag |

## Verification
The bench builds the block with DEPTH = 4 and TAG_W = 4. Four dispatches therefore fill the buffer, which puts the buffer-full override and the rejected offer on a full buffer within a few cycles. Sixteen tags leave room to give each scenario distinct tags. The small depth also lets three simultaneously waiting entries be woken out of order, which exposes the age ordering.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {
    ST_GO        = 3'd0,
    ST_LQ_FULL   = 3'd1,
    ST_SQ_FULL   = 3'd2,
    ST_BUF_FULL  = 3'd3,
    ST_GRP_STALL = 3'd4
  } sdc_status_e;
endpackage

// File: rtl/sdc_status.sv
module sdc_status
  import sdc_pkg::*;
(
  input  logic       buf_full_i,
  input  logic       grp_busy_i,
  input  logic       is_load_i,
  input  logic       is_store_i,
  input  logic       lq_full_i,
  input  logic       sq_full_i,
  output logic [2:0] code_o
);
  sdc_status_e code;
  always_comb begin
    // scheduler-side conditions dominate queue conditions
    if (buf_full_i)                   code = ST_BUF_FULL;
    else if (grp_busy_i)              code = ST_GRP_STALL;
    else if (is_load_i && lq_full_i)  code = ST_LQ_FULL;
    else if (is_store_i && sq_full_i) code = ST_SQ_FULL;
    else                              code = ST_GO;
  end
  assign code_o = code;
endmodule

// File: rtl/sdc_age_pick.sv
module sdc_age_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]        elig_i,
  input  logic [N-1:0][N-1:0] older_i,  // older_i[j][i]: j dispatched before i
  output logic [N-1:0]        grant_o
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < N; j++)
        if (j != i && elig_i[j] && older_i[j][i]) blocked = 1'b1;
      grant_o[i] = elig_i[i] && !blocked;
    end
  end
endmodule

// File: rtl/sdc_inflight.sv
module sdc_inflight #(
  parameter int unsigned TAG_W = 4,
  localparam int unsigned NT = 1 << TAG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NT-1:0]    set_i,
  input  logic [NT-1:0]    direct_i,
  input  logic             done_vld_i,
  input  logic [TAG_W-1:0] done_tag_i,
  output logic [NT-1:0]    notify_o
);
  logic [NT-1:0] pend_q;
  logic [NT-1:0] done_hot;

  always_comb begin
    done_hot = '0;
    if (done_vld_i) done_hot[done_tag_i] = 1'b1;
  end

  assign notify_o = direct_i | (done_hot & pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~done_hot) | set_i;
  end

  AST_DONE_NOTIFIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_vld_i && pend_q[done_tag_i]) |-> notify_o[done_tag_i]); // R9
  AST_DONE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_vld_i && pend_q[done_tag_i] && !set_i[done_tag_i]) |=> !pend_q[$past(done_tag_i)]); // R9
endmodule

// File: rtl/sched_dispatch_ctrl.sv
module sched_dispatch_ctrl
  import sdc_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TAG_W = 4,
  localparam int unsigned NT    = 1 << TAG_W,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disp_valid_i,
  input  logic [TAG_W-1:0] disp_tag_i,
  input  logic             disp_load_i,
  input  logic             disp_store_i,
  input  logic             disp_zero_lat_i,
  input  logic             disp_inorder_i,
  input  logic             grp_busy_i,
  input  logic             lq_full_i,
  input  logic             sq_full_i,
  output logic [2:0]       status_o,
  input  logic [NT-1:0]    opnd_rdy_i,
  input  logic [NT-1:0]    mem_ok_i,
  output logic             imm_valid_o,
  output logic [TAG_W-1:0] imm_tag_o,
  output logic             iss_valid_o,
  output logic [TAG_W-1:0] iss_tag_o,
  input  logic             exec_done_valid_i,
  input  logic [TAG_W-1:0] exec_done_tag_i,
  output logic [NT-1:0]    lsu_done_o
);
  logic [DEPTH-1:0]             v_q, rdy_q, mem_q, zl_q;
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
  logic [DEPTH-1:0][DEPTH-1:0]  older_q;
  logic [DEPTH-1:0]             wake, elig, grant;
  logic [CNT_W-1:0]             cnt;
  logic                         buf_full;
  logic [IDX_W-1:0]             iss_idx, free_idx;
  logic                         disp_mem, disp_rdy, accept, imm, alloc;
  logic [NT-1:0]                set_vec, direct_vec;
  logic                         past_ok_q;

  // promotion is combinational so a woken entry competes in the same cycle
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      wake[i] = opnd_rdy_i[tag_q[i]] && (!mem_q[i] || mem_ok_i[tag_q[i]]);
      elig[i] = v_q[i] && (rdy_q[i] || wake[i]);
    end
  end

  sdc_age_pick #(.N(DEPTH)) u_pick (
    .elig_i  (elig),
    .older_i (older_q),
    .grant_o (grant)
  );

  always_comb begin
    cnt      = '0;
    iss_idx  = '0;
    free_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt = cnt + CNT_W'(v_q[i]);
      if (grant[i]) iss_idx = IDX_W'(i);
    end
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!v_q[i]) free_idx = IDX_W'(i);
  end

  assign buf_full    = (cnt == CNT_W'(DEPTH));
  assign iss_valid_o = |grant;
  assign iss_tag_o   = tag_q[iss_idx];

  sdc_status u_status (
    .buf_full_i (buf_full),
    .grp_busy_i (grp_busy_i),
    .is_load_i  (disp_load_i),
    .is_store_i (disp_store_i),
    .lq_full_i  (lq_full_i),
    .sq_full_i  (sq_full_i),
    .code_o     (status_o)
  );

  assign disp_mem    = disp_load_i || disp_store_i;
  assign disp_rdy    = opnd_rdy_i[disp_tag_i] && (!disp_mem || mem_ok_i[disp_tag_i]);
  assign accept      = disp_valid_i && (status_o == ST_GO);
  assign imm         = accept && disp_rdy && (disp_zero_lat_i || disp_inorder_i);
  assign alloc       = accept && !imm;
  assign imm_valid_o = imm;
  assign imm_tag_o   = disp_tag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q     <= '0;
      rdy_q   <= '0;
      mem_q   <= '0;
      zl_q    <= '0;
      tag_q   <= '0;
      older_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc && free_idx == IDX_W'(i)) begin
          v_q[i]   <= 1'b1;
          rdy_q[i] <= disp_rdy;
          mem_q[i] <= disp_mem;
          zl_q[i]  <= disp_zero_lat_i;
          tag_q[i] <= disp_tag_i;
          for (int j = 0; j < DEPTH; j++) begin
            older_q[j][i] <= v_q[j] && !grant[j];
            older_q[i][j] <= 1'b0;
          end
        end else if (grant[i]) begin
          v_q[i]   <= 1'b0;
          rdy_q[i] <= 1'b0;
        end else if (elig[i]) begin
          rdy_q[i] <= 1'b1;
        end
      end
    end
  end

  // load/store unit notification sources
  always_comb begin
    set_vec    = '0;
    direct_vec = '0;
    if (imm && disp_mem) begin
      if (disp_zero_lat_i) direct_vec[disp_tag_i] = 1'b1;
      else                 set_vec[disp_tag_i]    = 1'b1;
    end
    if (iss_valid_o && mem_q[iss_idx]) begin
      if (zl_q[iss_idx]) direct_vec[iss_tag_o] = 1'b1;
      else               set_vec[iss_tag_o]    = 1'b1;
    end
  end

  sdc_inflight #(.TAG_W(TAG_W)) u_inflight (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .direct_i   (direct_vec),
    .done_vld_i (exec_done_valid_i),
    .done_tag_i (exec_done_tag_i),
    .notify_o   (lsu_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  AST_BUF_FULL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q == '1) |-> (status_o == ST_BUF_FULL)); // R2
  AST_GRP_OVER_QUEUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q != '1 && grp_busy_i) |-> (status_o == ST_GRP_STALL)); // R2
  AST_TAKE_ONLY_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_valid_o |-> (status_o == ST_GO && disp_valid_i)); // R4
  AST_SLOT_ACCOUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> (int'($countones(v_q)) == int'($past($countones(v_q)))
                   + int'($past(alloc)) - int'($past(iss_valid_o)))); // R8
  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant)); // R7
  AST_GRANT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> v_q[iss_idx]); // R7
  AST_BYPASS_NO_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imm_valid_o && !iss_valid_o) |=> ($countones(v_q) == $past($countones(v_q)))); // R5
endmodule

// File: tb/sim_sched_dispatch_ctrl.sv
module sim_sched_dispatch_ctrl;
  localparam int DEPTH = 4;
  localparam int TAG_W = 4;
  localparam int NT    = 1 << TAG_W;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             disp_valid = 1'b0;
  logic [TAG_W-1:0] disp_tag = '0;
  logic             disp_load = 1'b0, disp_store = 1'b0, disp_zl = 1'b0, disp_io = 1'b0;
  logic             grp_busy = 1'b0, lq_full = 1'b0, sq_full = 1'b0;
  logic [2:0]       status;
  logic [NT-1:0]    opnd_rdy = '0, mem_ok = '0;
  logic             imm_valid, iss_valid;
  logic [TAG_W-1:0] imm_tag, iss_tag;
  logic             done_vld = 1'b0;
  logic [TAG_W-1:0] done_tag = '0;
  logic [NT-1:0]    lsu_done;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sched_dispatch_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(disp_valid), .disp_tag_i(disp_tag),
    .disp_load_i(disp_load), .disp_store_i(disp_store),
    .disp_zero_lat_i(disp_zl), .disp_inorder_i(disp_io),
    .grp_busy_i(grp_busy), .lq_full_i(lq_full), .sq_full_i(sq_full),
    .status_o(status), .opnd_rdy_i(opnd_rdy), .mem_ok_i(mem_ok),
    .imm_valid_o(imm_valid), .imm_tag_o(imm_tag),
    .iss_valid_o(iss_valid), .iss_tag_o(iss_tag),
    .exec_done_valid_i(done_vld), .exec_done_tag_i(done_tag),
    .lsu_done_o(lsu_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic offer(input bit v, input int tag, input bit ld, input bit st,
                       input bit zl, input bit io);
    disp_valid = v; disp_tag = TAG_W'(tag);
    disp_load = ld; disp_store = st; disp_zl = zl; disp_io = io;
    #1;
  endtask

  task automatic idle();
    offer(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    idle();
    chk(status == 3'd0, "R1 reset code", status, 0);
    chk(!iss_valid, "R7 reset issue", iss_valid, 0);
    chk(lsu_done == '0, "R9 reset notify", int'(lsu_done), 0);
  endtask

  task automatic t_status();
    offer(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0); grp_busy = 1; lq_full = 1; #1;
    chk(status == 3'd4, "R2 group over queue", status, 4);
    grp_busy = 0; offer(1'b0, 0, 1'b1, 1'b1, 1'b0, 1'b0); sq_full = 1; #1;
    chk(status == 3'd1, "R3 load before store", status, 1);
    offer(1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(status == 3'd2, "R3 store full", status, 2);
    offer(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(status == 3'd0, "R3 non-mem ignores queues", status, 0);
    lq_full = 0; sq_full = 0; #1;
  endtask

  task automatic t_bypass();
    opnd_rdy[1] = 1; mem_ok[1] = 1;
    offer(1'b1, 1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk(imm_valid && imm_tag == 1, "R5 bypass tag", int'(imm_tag), 1);
    chk(lsu_done[1], "R9 zero-lat notify now", lsu_done[1], 1);
    step(); idle();
    chk(!iss_valid, "R5 no slot taken", iss_valid, 0);
  endtask

  task automatic t_wait_order();
    for (int t = 2; t <= 4; t++) begin
      offer(1'b1, t, 1'b0, 1'b0, 1'b0, 1'b0);
      chk(!imm_valid, "R6 not bypassed", imm_valid, 0);
      step();
    end
    idle();
    chk(!iss_valid, "R6 held waiting", iss_valid, 0);
    opnd_rdy[3] = 1; opnd_rdy[4] = 1; #1;
    chk(iss_valid && iss_tag == 3, "R7 oldest woken first", int'(iss_tag), 3);
    step();
    chk(iss_valid && iss_tag == 4, "R7 next oldest", int'(iss_tag), 4);
    step();
    chk(!iss_valid, "R6 tag2 still waits", iss_valid, 0);
    opnd_rdy[2] = 1; #1;
    chk(iss_valid && iss_tag == 2, "R6 wake same cycle", int'(iss_tag), 2);
    step();
  endtask

  task automatic t_mem_order();
    opnd_rdy[5] = 1; mem_ok[5] = 0;
    offer(1'b1, 5, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(!imm_valid, "R6 ordering blocks bypass", imm_valid, 0);
    step(); idle();
    chk(!iss_valid, "R6 ordering wait", iss_valid, 0);
    mem_ok[5] = 1; #1;
    chk(iss_valid && iss_tag == 5, "R6 ordering cleared", int'(iss_tag), 5);
    chk(!lsu_done[5], "R9 no early notify", lsu_done[5], 0);
    step();
    done_vld = 1; done_tag = 5; #1;
    chk(lsu_done[5], "R9 notify on done", lsu_done[5], 1);
    step();
    chk(!lsu_done[5], "R9 notify once", lsu_done[5], 0);
    done_tag = 7; #1;
    chk(lsu_done == '0, "R9 non-mem silent", int'(lsu_done), 0);
    done_vld = 0;
    opnd_rdy[8] = 1; mem_ok[8] = 1;
    offer(1'b1, 8, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(!imm_valid, "R7 ready list not bypass", imm_valid, 0);
    step(); idle();
    chk(iss_valid && iss_tag == 8, "R7 ready list issue", int'(iss_tag), 8);
    step();
  endtask

  task automatic t_full();
    for (int t = 9; t <= 12; t++) begin
      offer(1'b1, t, 1'b0, 1'b0, 1'b0, 1'b0);
      step();
    end
    grp_busy = 1; lq_full = 1;
    offer(1'b1, 13, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(status == 3'd3, "R2 buffer full wins", status, 3);
    step();
    idle();
    for (int t = 9; t <= 13; t++) opnd_rdy[t] = 1;
    #1;
    chk(iss_valid && iss_tag == 9, "R7 drain oldest", int'(iss_tag), 9);
    step();
    chk(status == 3'd4, "R8 slot freed", status, 4);
    grp_busy = 0; lq_full = 0; #1;
    chk(status == 3'd0, "R8 go after free", status, 0);
    for (int t = 10; t <= 12; t++) begin
      chk(iss_valid && iss_tag == TAG_W'(t), "R7 drain order", int'(iss_tag), t);
      step();
    end
    chk(!iss_valid, "R4 rejected offer absent", iss_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_bypass();
    t_wait_order();
    t_mem_order();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule